// File: doc/BRIEF.md
# Frequency Gate Edge Synchronizer

This block turns a measurement gate request into a start pulse, a stop pulse and two gate levels. All of them are aligned to rising edges of the signal being measured, which also clocks the block. The start and stop strobes feed a time interval counter. The frequency-count gate enables a cycle counter on the same input. The event gate enables event counters.

The gate request comes from one of two places:
- **Internal gating:** a control bit.
- **External gating:** a discriminated external input. The control bit then picks its polarity.

Each side of the gate passes through arm flops and then through a short chain of re-synchronization stages clocked by the measured signal. Every stop-side stage is held clear until its start-side partner has set. A measurement therefore always spans at least one whole input period.

A single-cycle mode measures exactly one input period right after a load. A fast mode skips the first re-synchronization stage. A synchronous load pulse clears every stage and re-arms the block. A done strobe marks the cycle in which stop is captured.

All inputs are sampled on rising edges of the clock. In the requirements:
- The "gate level" is `gate_req_i` in internal mode and `ext_in_i XOR gate_req_i` in external mode.
- "Edge 0" is the first rising edge at which a new gate level is sampled.
- "Edge n" is the n-th edge after edge 0.
- "After edge n" means the value visible once edge n has passed.

Top module: `freq_gate_sync`

## Requirements
- R1: With fast mode off, a gate level first sampled high at edge 0 makes `start_o` rise after edge 1, and `start_o` stays high until the next load.
- R2: With fast mode off, a gate level first sampled low at edge f, after the gate opened, makes `stop_o` rise after edge f+1, and `stop_o` stays high until the next load.
- R3: `stop_o` is never high while `start_o` is low. A gate level sampled high at exactly one edge still yields a start-to-stop spacing of exactly one clock period. In general the spacing equals the number of edges at which the gate level was sampled high.
- R4: `freq_gate_o` rises together with `start_o` and falls together with `stop_o`.
- R5: `event_gate_o` is high after each edge from the edge that samples the gate level high up to, but not including, the edge that samples it low.
- R6: With `ext_gate_mode_i` = 1, the gate level is `ext_in_i XOR gate_req_i`, so `gate_req_i` = 1 inverts the external polarity. With `ext_gate_mode_i` = 0, `ext_in_i` has no effect.
- R7: With `single_mode_i` = 1 and fast mode off, both arm stages set on the first edge after load is released (edge 0). `start_o` rises after edge 1 and `stop_o` after edge 2, the gate inputs are ignored, and `event_gate_o` stays low.
- R8: With `fast_mode_i` = 1, start and stop each appear one edge earlier than in R1, R2 and R7: after edge 0 and after edge f. In single-cycle mode that is after edge 0 and after edge 1.
- R9: `load_i` sampled high at an edge clears `start_o`, `stop_o`, `freq_gate_o`, `event_gate_o` and `done_o` after that edge.
- R10: `done_o` is high for exactly one cycle, the cycle in which `stop_o` first becomes high, and does not pulse again before the next load.
- R11: After reset all outputs are low, and they stay low while the gate level stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fin | input | 1 | Measured frequency input, used as the clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Synchronous clear and re-arm pulse |
| gate_req_i | input | 1 | Internal gate request, or the polarity select in external mode |
| ext_in_i | input | 1 | Discriminated external gate input |
| ext_gate_mode_i | input | 1 | 1 selects external gating |
| single_mode_i | input | 1 | 1 selects single-period measurement |
| fast_mode_i | input | 1 | 1 bypasses the first re-synchronization stage |
| start_o | output | 1 | Start strobe to the interval counter (sticky until load) |
| stop_o | output | 1 | Stop strobe to the interval counter (sticky until load) |
| freq_gate_o | output | 1 | Enables counting of input cycles |
| event_gate_o | output | 1 | Enables event counting |
| done_o | output | 1 | One-cycle strobe when stop is captured |

## Verification
The main function is swept over three gate sources:
- the internal bit, with the external input toggling as noise;
- the external input at normal polarity;
- the external input at inverted polarity.

Each source is run with fast mode off and on, gate widths of one to six edges, and opening delays of zero to two edges after load.

The width sweep tells a correct two-stage alignment apart from an off-by-one on either the start or the stop side. The one-edge width exposes any loss of the minimum-one-period guarantee. The polarity runs separate a true XOR select from a plain pass-through.

Single-cycle runs in both fast settings check the three-edge and two-edge sequences after load. A check right after every load confirms the clearing from whatever state the previous run left.

// File: rtl/fgs_pkg.sv
package fgs_pkg;

  // Edge events decoded from the sampled gate level.
  typedef struct packed {
    logic rise;
    logic fall;
  } gate_edge_t;

  localparam int unsigned FGS_DEFAULT_DEPTH = 2;

endpackage

// File: rtl/fgs_gate_src.sv
module fgs_gate_src
  import fgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_req,
  input  logic       ext_in,
  input  logic       ext_mode,
  output gate_edge_t edges
);

  logic level;
  logic level_q;
  logic level_n;

  // Polarity select: in external mode the control bit flips the input.
  always_comb begin
    if (ext_mode) begin
      level = ext_in ^ gate_req;
    end else begin
      level = gate_req;
    end
    level_n = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_n;
    end
  end

  always_comb begin
    edges.rise = level & ~level_q;
    edges.fall = ~level & level_q;
  end

endmodule

// File: rtl/fgs_arm.sv
module fgs_arm
  import fgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       single,
  input  gate_edge_t edges,
  output logic       arm_a_any,
  output logic       arm_b_any,
  output logic       arm_a_q,
  output logic       arm_b_q
);

  logic arm_a_n;
  logic arm_b_n;
  logic arm_en;

  // Set-or-held view used by the first re-synchronization stage.
  always_comb begin
    arm_a_any = arm_a_q | edges.rise | single;
    arm_b_any = arm_b_q | single | (edges.fall & arm_a_q);
  end

  always_comb begin
    arm_en  = 1'b1;
    arm_a_n = arm_a_q;
    arm_b_n = arm_b_q;
    if (load) begin
      arm_a_n = 1'b0;
      arm_b_n = 1'b0;
    end else begin
      arm_a_n = arm_a_any;
      arm_b_n = arm_b_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_a_q <= 1'b0;
      arm_b_q <= 1'b0;
    end else if (arm_en) begin
      arm_a_q <= arm_a_n;
      arm_b_q <= arm_b_n;
    end
  end

  AST_ARM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    arm_b_q |-> arm_a_q); // R5

endmodule

// File: rtl/fgs_resync.sv
module fgs_resync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic fast,
  input  logic arm_a_any,
  input  logic arm_b_any,
  output logic start_n,
  output logic stop_n,
  output logic start_q,
  output logic stop_q
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] st_q;
  logic [DEPTH-1:0] sp_q;
  logic [DEPTH-1:0] st_n;
  logic [DEPTH-1:0] sp_n;
  logic [DEPTH-1:0] st_feed;
  logic [DEPTH-1:0] sp_feed;

  // Stage feeds: fast mode lets stage 1 take the arm flops directly.
  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (i == 0) begin
        st_feed[i] = arm_a_any;
        sp_feed[i] = arm_b_any;
      end else if (i == 1 && fast) begin
        st_feed[i] = arm_a_any;
        sp_feed[i] = arm_b_any;
      end else begin
        st_feed[i] = st_q[i-1];
        sp_feed[i] = sp_q[i-1];
      end
    end
  end

  // Each stop stage is held clear until its start partner has set.
  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (load) begin
        st_n[i] = 1'b0;
        sp_n[i] = 1'b0;
      end else begin
        st_n[i] = st_q[i] | st_feed[i];
        sp_n[i] = sp_q[i] | (sp_feed[i] & st_q[i]);
      end
    end
  end

  generate
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[g] <= 1'b0;
          sp_q[g] <= 1'b0;
        end else begin
          st_q[g] <= st_n[g];
          sp_q[g] <= sp_n[g];
        end
      end
    end
  endgenerate

  always_comb begin
    start_n = st_n[LAST];
    stop_n  = sp_n[LAST];
    start_q = st_q[LAST];
    stop_q  = sp_q[LAST];
  end

  AST_STOP_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q[LAST] |-> st_q[LAST]); // R3
  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[LAST] && !load) |=> st_q[LAST]); // R1

endmodule

// File: rtl/fgs_outputs.sv
module fgs_outputs (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic start_n,
  input  logic stop_n,
  input  logic stop_q,
  output logic fgate_q,
  output logic done_q
);

  logic fgate_n;
  logic done_n;

  always_comb begin
    if (load) begin
      fgate_n = 1'b0;
      done_n  = 1'b0;
    end else begin
      fgate_n = (fgate_q | start_n) & ~stop_n;
      done_n  = stop_n & ~stop_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fgate_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      fgate_q <= fgate_n;
      done_q  <= done_n;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10

endmodule

// File: rtl/freq_gate_sync.sv
module freq_gate_sync
  import fgs_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = FGS_DEFAULT_DEPTH
) (
  input  logic clk_fin,
  input  logic rst_n,
  input  logic load_i,
  input  logic gate_req_i,
  input  logic ext_in_i,
  input  logic ext_gate_mode_i,
  input  logic single_mode_i,
  input  logic fast_mode_i,
  output logic start_o,
  output logic stop_o,
  output logic freq_gate_o,
  output logic event_gate_o,
  output logic done_o
);

  logic       rst_meta_q;
  logic       rst_sync_q;
  gate_edge_t edges;
  logic       arm_a_any;
  logic       arm_b_any;
  logic       arm_a_q;
  logic       arm_b_q;
  logic       start_n;
  logic       stop_n;
  logic       start_q;
  logic       stop_q;
  logic       fgate_q;
  logic       done_q;

  // Reset asserts at once and releases on the measured clock.
  always_ff @(posedge clk_fin or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  fgs_gate_src u_src (
    .clk      (clk_fin),
    .rst_n    (rst_sync_q),
    .gate_req (gate_req_i),
    .ext_in   (ext_in_i),
    .ext_mode (ext_gate_mode_i),
    .edges    (edges)
  );

  fgs_arm u_arm (
    .clk       (clk_fin),
    .rst_n     (rst_sync_q),
    .load      (load_i),
    .single    (single_mode_i),
    .edges     (edges),
    .arm_a_any (arm_a_any),
    .arm_b_any (arm_b_any),
    .arm_a_q   (arm_a_q),
    .arm_b_q   (arm_b_q)
  );

  fgs_resync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk       (clk_fin),
    .rst_n     (rst_sync_q),
    .load      (load_i),
    .fast      (fast_mode_i),
    .arm_a_any (arm_a_any),
    .arm_b_any (arm_b_any),
    .start_n   (start_n),
    .stop_n    (stop_n),
    .start_q   (start_q),
    .stop_q    (stop_q)
  );

  fgs_outputs u_out (
    .clk     (clk_fin),
    .rst_n   (rst_sync_q),
    .load    (load_i),
    .start_n (start_n),
    .stop_n  (stop_n),
    .stop_q  (stop_q),
    .fgate_q (fgate_q),
    .done_q  (done_q)
  );

  always_comb begin
    start_o      = start_q;
    stop_o       = stop_q;
    freq_gate_o  = fgate_q;
    event_gate_o = arm_a_q & ~arm_b_q;
    done_o       = done_q;
  end

  AST_FGATE_INSIDE_START: assert property (@(posedge clk_fin) disable iff (!rst_sync_q)
    freq_gate_o |-> (start_o && !stop_o)); // R4
  AST_LOAD_CLEARS: assert property (@(posedge clk_fin) disable iff (!rst_sync_q)
    load_i |=> (!start_o && !stop_o && !freq_gate_o && !event_gate_o && !done_o)); // R9
  AST_DONE_AT_STOP: assert property (@(posedge clk_fin) disable iff (!rst_sync_q)
    done_o |-> stop_o); // R10
  AST_EGATE_BEFORE_STOP: assert property (@(posedge clk_fin) disable iff (!rst_sync_q)
    event_gate_o |-> !stop_o); // R5

endmodule

// File: tb/freq_gate_sync_test.sv
module freq_gate_sync_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic gate_req_i = 1'b0;
  logic ext_in_i = 1'b0;
  logic ext_gate_mode_i = 1'b0;
  logic single_mode_i = 1'b0;
  logic fast_mode_i = 1'b0;
  logic start_o, stop_o, freq_gate_o, event_gate_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_gate_sync uut (
    .clk_fin         (clk),
    .rst_n           (rst_n),
    .load_i          (load_i),
    .gate_req_i      (gate_req_i),
    .ext_in_i        (ext_in_i),
    .ext_gate_mode_i (ext_gate_mode_i),
    .single_mode_i   (single_mode_i),
    .fast_mode_i     (fast_mode_i),
    .start_o         (start_o),
    .stop_o          (stop_o),
    .freq_gate_o     (freq_gate_o),
    .event_gate_o    (event_gate_o),
    .done_o          (done_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // mode 0: internal bit (external input toggles as noise)
  // mode 1: external, normal polarity; mode 2: external, inverted
  task automatic drive(input int mode, input bit g, input int k);
    case (mode)
      0: begin gate_req_i = g; ext_in_i = k[0]; end
      1: begin gate_req_i = 1'b0; ext_in_i = g; end
      default: begin gate_req_i = 1'b1; ext_in_i = ~g; end
    endcase
  endtask

  task automatic run(input int mode, input bit fast, input bit single,
                     input int d, input int w);
    int tcyc;
    int lat;
    int es, ep;
    int got_s, got_p, done_cnt, done_k, fg_err, eg_err;
    string tag_s, tag_p;
    bit g, eg_exp, fg_exp;
    lat = fast ? 0 : 1;
    if (single) begin
      es = lat; ep = lat + 1; tcyc = 5;
      tag_s = fast ? "R8 single start" : "R7 start";
      tag_p = fast ? "R8 single stop" : "R7 stop";
    end else begin
      es = d + lat; ep = d + w + lat; tcyc = d + w + 4;
      if (mode != 0) begin
        tag_s = fast ? "R6/R8 start" : "R6/R1 start";
        tag_p = fast ? "R6/R8 stop" : "R6/R2 stop";
      end else begin
        tag_s = fast ? "R8 start" : "R1 start";
        tag_p = fast ? "R8 stop" : "R2 stop";
      end
    end
    // Load cycle with the gate level low.
    @(negedge clk);
    ext_gate_mode_i = (mode != 0);
    fast_mode_i = fast;
    single_mode_i = single;
    drive(mode, 1'b0, 1);
    load_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 clear", int'({start_o, stop_o, freq_gate_o, event_gate_o, done_o}), 0);
    load_i = 1'b0;
    got_s = -1; got_p = -1; done_cnt = 0; done_k = -1; fg_err = 0; eg_err = 0;
    for (int k = 0; k < tcyc; k++) begin
      g = !single && (k >= d) && (k < d + w);
      // Single mode must ignore gate activity: wiggle it anyway.
      if (single) g = k[0];
      drive(mode, g, k);
      @(posedge clk);
      @(negedge clk);
      if (start_o && got_s < 0) got_s = k;
      if (stop_o && got_p < 0) got_p = k;
      if (done_o) begin done_cnt++; done_k = k; end
      fg_exp = (k >= es) && (k < ep);
      if (freq_gate_o != fg_exp) fg_err++;
      eg_exp = !single && (k >= d) && (k < d + w);
      if (event_gate_o != eg_exp) eg_err++;
      if (stop_o && !start_o) chk("R3 stop without start", 1, 0);
    end
    chk(tag_s, got_s, es);
    chk(tag_p, got_p, ep);
    chk("R3 spacing", got_p - got_s, single ? 1 : w);
    chk("R10 done count", done_cnt, 1);
    chk("R10 done cycle", done_k, ep);
    chk("R4 freq gate errors", fg_err, 0);
    chk(single ? "R7 event gate errors" : "R5 event gate errors", eg_err, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11 reset state",
        int'({start_o, stop_o, freq_gate_o, event_gate_o, done_o}), 0);
    for (int mode = 0; mode < 3; mode++)
      for (int fast = 0; fast < 2; fast++)
        for (int w = 1; w <= 6; w++)
          for (int d = 0; d < 3; d++)
            run(mode, fast[0], 1'b0, d, w);
    for (int mode = 0; mode < 3; mode++)
      for (int fast = 0; fast < 2; fast++)
        run(mode, fast[0], 1'b1, 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule